// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This core runs a straight-line program in which every instruction names at most one 16-bit data address. The accumulator is both the implicit second operand and the destination. Instruction bytes arrive one per cycle over a byte-wide fetch port, and 32-bit words move over a separate data port. Both memories are expected to answer in the same cycle that the core presents an address.

Each non-halt instruction has three bytes: an opcode byte followed by a two-byte address. The instruction then makes one data access in the cycle after the last address byte. A one-byte halt instruction stops the core. Two counters report the memory traffic a program causes: the instruction bytes fetched and the data bytes moved. Code size and total bandwidth can therefore be read straight from the ports at the end of a run.

Top module: `acc_core`

## Requirements
- R1: While reset is held, and immediately after it, the accumulator is zero, both traffic counters are zero, and done and error are low.
- R2: The core fetches exactly one instruction byte per fetch cycle. Fetch addresses start at 0 and step by one. The data address is assembled from the two bytes after the opcode, low byte first.
- R3: Opcode 0x01 (load) copies the 32-bit word at the named address into the accumulator.
- R4: Opcode 0x02 (store) writes the accumulator to the named address and leaves the accumulator unchanged.
- R5: Opcode 0x10 (add) replaces the accumulator with the accumulator plus the word at the named address, modulo 2^32.
- R6: Opcode 0x11 (subtract) replaces the accumulator with the accumulator minus the word at the named address, modulo 2^32. The accumulator is the minuend.
- R7: Opcode 0xFF (halt) raises done once it is decoded. After that there are no further fetches or data accesses, and the accumulator and counters stay frozen.
- R8: Any other opcode raises both error and done. It performs no data access.
- R9: The instruction byte counter grows by one for every fetched byte, including a halt or unknown opcode.
- R10: The data byte counter grows by four for every data read or write.
- R11: A non-halt instruction takes four cycles and makes exactly one data access, in its fourth cycle. A read and a write never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instAddr | output | 16 | Byte address of the instruction fetch |
| instRd | output | 1 | Instruction byte fetch strobe |
| instData | input | 8 | Instruction byte returned in the same cycle |
| dataAddr | output | 16 | Data word address |
| dataRd | output | 1 | Data read strobe |
| dataWr | output | 1 | Data write strobe |
| dataWdata | output | 32 | Word written on a store |
| dataRdata | input | 32 | Word returned in the same cycle as dataRd |
| acc | output | 32 | Accumulator value |
| instBytes | output | 16 | Instruction bytes fetched since reset |
| dataBytes | output | 16 | Data bytes moved since reset |
| done | output | 1 | Core has stopped |
| error | output | 1 | Core stopped on an unknown opcode |

## Verification
The hardest case to reach from the ports is a program that stops on an unrecognised opcode partway through. It has to be shown that nothing after that point is fetched or touched. The bench reaches this with a second program whose second opcode is an undefined byte, and places a valid store behind it. The scoreboard then has to see no write, the counters have to read exactly four instruction bytes and four data bytes, and the state has to hold over many idle cycles. Byte order of the address is exposed by data addresses whose two bytes differ, so a swap would land a write on another word of the model memory.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam logic [7:0] OPC_LOAD  = 8'h01;
  localparam logic [7:0] OPC_STORE = 8'h02;
  localparam logic [7:0] OPC_ADD   = 8'h10;
  localparam logic [7:0] OPC_SUB   = 8'h11;
  localparam logic [7:0] OPC_HALT  = 8'hFF;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ALO,
    ST_AHI,
    ST_EXEC,
    ST_HALT
  } ctlState_t;

  typedef enum logic [1:0] {
    K_LOAD,
    K_STORE,
    K_ADD,
    K_SUB
  } opKind_t;

  typedef enum logic [1:0] {
    ACC_PASS,
    ACC_ADD,
    ACC_SUB
  } accFn_t;

  typedef struct packed {
    logic   instRd;
    logic   addrLo;
    logic   addrHi;
    logic   dataRd;
    logic   dataWr;
    logic   accWe;
    accFn_t accFn;
  } strobes_t;

endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_core_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] opcode,
  output strobes_t   strobes,
  output logic       done,
  output logic       error
);

  ctlState_t state, stateNext;
  opKind_t   kind, kindNext;
  logic      errNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_OPC;
      kind  <= K_LOAD;
      error <= 1'b0;
    end else begin
      state <= stateNext;
      kind  <= kindNext;
      error <= errNext;
    end
  end

  always_comb begin
    strobes   = '0;
    stateNext = state;
    kindNext  = kind;
    errNext   = error;
    unique case (state)
      ST_OPC: begin
        strobes.instRd = 1'b1;
        stateNext      = ST_ALO;
        case (opcode)
          OPC_LOAD:  kindNext = K_LOAD;
          OPC_STORE: kindNext = K_STORE;
          OPC_ADD:   kindNext = K_ADD;
          OPC_SUB:   kindNext = K_SUB;
          OPC_HALT:  stateNext = ST_HALT;
          default: begin
            stateNext = ST_HALT;
            errNext   = 1'b1;
          end
        endcase
      end
      ST_ALO: begin
        strobes.instRd = 1'b1;
        strobes.addrLo = 1'b1;
        stateNext      = ST_AHI;
      end
      ST_AHI: begin
        strobes.instRd = 1'b1;
        strobes.addrHi = 1'b1;
        stateNext      = ST_EXEC;
      end
      ST_EXEC: begin
        stateNext = ST_OPC;
        unique case (kind)
          K_LOAD: begin
            strobes.dataRd = 1'b1;
            strobes.accWe  = 1'b1;
            strobes.accFn  = ACC_PASS;
          end
          K_STORE: strobes.dataWr = 1'b1;
          K_ADD: begin
            strobes.dataRd = 1'b1;
            strobes.accWe  = 1'b1;
            strobes.accFn  = ACC_ADD;
          end
          K_SUB: begin
            strobes.dataRd = 1'b1;
            strobes.accWe  = 1'b1;
            strobes.accFn  = ACC_SUB;
          end
        endcase
      end
      default: stateNext = ST_HALT;
    endcase
  end

  assign done = (state == ST_HALT);

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.dataRd && strobes.dataWr)); // R11
  AST_ACCESS_AFTER_HI: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.dataRd || strobes.dataWr) |-> $past(strobes.addrHi)); // R11
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(strobes.instRd || strobes.dataRd || strobes.dataWr)); // R7
  AST_ERR_DONE: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done); // R7

endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_core_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [7:0]        instData,
  input  logic [DATA_W-1:0] dataRdata,
  output logic [PC_W-1:0]   instAddr,
  output logic [15:0]       dataAddr,
  output logic [DATA_W-1:0] dataWdata,
  output logic [DATA_W-1:0] acc,
  output logic [CNT_W-1:0]  instBytes,
  output logic [CNT_W-1:0]  dataBytes
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [CNT_W-1:0] WORD_INC = CNT_W'(WORD_BYTES);

  logic [PC_W-1:0]   pc;
  logic [15:0]       addrReg;
  logic [DATA_W-1:0] accNext;

  always_comb begin
    unique case (strobes.accFn)
      ACC_ADD: accNext = acc + dataRdata;
      ACC_SUB: accNext = acc - dataRdata;
      default: accNext = dataRdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc        <= '0;
      addrReg   <= '0;
      acc       <= '0;
      instBytes <= '0;
      dataBytes <= '0;
    end else begin
      if (strobes.instRd) begin
        pc        <= pc + 1'b1;
        instBytes <= instBytes + 1'b1;
      end
      if (strobes.addrLo) addrReg[7:0]  <= instData;
      if (strobes.addrHi) addrReg[15:8] <= instData;
      if (strobes.accWe) acc <= accNext;
      if (strobes.dataRd || strobes.dataWr) dataBytes <= dataBytes + WORD_INC;
    end
  end

  assign instAddr  = pc;
  assign dataAddr  = addrReg;
  assign dataWdata = acc;

  AST_INST_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.instRd |=> instBytes == $past(instBytes) + 1'b1); // R9
  AST_DATA_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.dataRd || strobes.dataWr) |=> dataBytes == $past(dataBytes) + WORD_INC); // R10
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accWe |=> $stable(acc)); // R4
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.instRd |=> $stable(instAddr)); // R2

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [PC_W-1:0]   instAddr,
  output logic              instRd,
  input  logic [7:0]        instData,
  output logic [15:0]       dataAddr,
  output logic              dataRd,
  output logic              dataWr,
  output logic [DATA_W-1:0] dataWdata,
  input  logic [DATA_W-1:0] dataRdata,
  output logic [DATA_W-1:0] acc,
  output logic [CNT_W-1:0]  instBytes,
  output logic [CNT_W-1:0]  dataBytes,
  output logic              done,
  output logic              error
);

  strobes_t strobes;

  acc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opcode  (instData),
    .strobes (strobes),
    .done    (done),
    .error   (error)
  );

  acc_dpath #(
    .PC_W   (PC_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .instData  (instData),
    .dataRdata (dataRdata),
    .instAddr  (instAddr),
    .dataAddr  (dataAddr),
    .dataWdata (dataWdata),
    .acc       (acc),
    .instBytes (instBytes),
    .dataBytes (dataBytes)
  );

  assign instRd = strobes.instRd;
  assign dataRd = strobes.dataRd;
  assign dataWr = strobes.dataWr;

endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] instAddr;
  logic        instRd;
  logic [7:0]  instData;
  logic [15:0] dataAddr;
  logic        dataRd, dataWr;
  logic [31:0] dataWdata, dataRdata;
  logic [31:0] acc;
  logic [15:0] instBytes, dataBytes;
  logic        done, error;

  always #10 clk = ~clk;

  acc_core dut (
    .clk(clk), .rstN(rstN), .instAddr(instAddr), .instRd(instRd), .instData(instData),
    .dataAddr(dataAddr), .dataRd(dataRd), .dataWr(dataWr), .dataWdata(dataWdata),
    .dataRdata(dataRdata), .acc(acc), .instBytes(instBytes), .dataBytes(dataBytes),
    .done(done), .error(error)
  );

  logic [7:0]  imem [256];
  logic [31:0] dmem [256];
  logic [31:0] mm   [256];
  logic [47:0] expQ [$];

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int fetchCnt = 0;
  int expCycles, expInst, expData;
  logic [31:0] expAcc;
  logic        expErr;

  assign instData  = imem[instAddr[7:0]];
  assign dataRdata = dmem[dataAddr[7:0]];

  always @(posedge clk) if (dataWr) dmem[dataAddr[7:0]] <= dataWdata;

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor: pops expected writes, checks fetch order and access slot
  always @(negedge clk) begin
    if (!rstN) begin
      cyc = 0;
      fetchCnt = 0;
    end else if (!done) begin
      if (instRd) begin
        check(instAddr == 16'(fetchCnt), "R2 fetch address", 48'(instAddr), 48'(fetchCnt));
        fetchCnt++;
      end
      if (dataRd || dataWr)
        check((cyc % 4) == 3 && !(dataRd && dataWr), "R11 access slot", 48'(cyc % 4), 48'd3);
      if (dataWr) begin
        if (expQ.size() == 0) check(1'b0, "R4 unexpected write", {dataAddr, dataWdata}, 48'd0);
        else begin
          logic [47:0] e;
          e = expQ.pop_front();
          check({dataAddr, dataWdata} == e, "R4 write addr/data", {dataAddr, dataWdata}, e);
        end
      end
      cyc++;
    end
  end

  // Driver side: interpret program and queue expected writes
  task automatic buildExpected();
    int pc = 0;
    logic [31:0] a = 0;
    logic [15:0] ad;
    logic [7:0] op;
    expInst = 0; expData = 0; expCycles = 0; expErr = 0;
    for (int i = 0; i < 256; i++) mm[i] = dmem[i];
    for (int n = 0; n < 80; n++) begin
      op = imem[pc[7:0]];
      expInst++; expCycles++; pc++;
      if (op == 8'hFF) break;
      if (!(op == 8'h01 || op == 8'h02 || op == 8'h10 || op == 8'h11)) begin
        expErr = 1; break;
      end
      ad = {imem[8'(pc + 1)], imem[pc[7:0]]};
      pc += 2; expInst += 2; expData += 4; expCycles += 3;
      case (op)
        8'h01: a = mm[ad[7:0]];
        8'h02: begin mm[ad[7:0]] = a; expQ.push_back({ad, a}); end
        8'h10: a = a + mm[ad[7:0]];
        default: a = a - mm[ad[7:0]];
      endcase
    end
    expAcc = a;
  endtask

  task automatic putIns(inout int p, input logic [7:0] op, input logic [15:0] ad);
    imem[p[7:0]] = op; imem[8'(p + 1)] = ad[7:0]; imem[8'(p + 2)] = ad[15:8];
    p += 3;
  endtask

  task automatic runAndWait(output bit ok);
    int n = 0;
    ok = 1;
    rstN = 1'b1;
    while (!done && n < 2000) begin @(posedge clk); n++; end
    if (!done) begin ok = 0; check(1'b0, "R7 watchdog", 48'(n), 48'd0); end
    @(negedge clk);
  endtask

  localparam logic [15:0] AA = 16'h0110, AB = 16'h0211, AC = 16'h0312, AD = 16'h0413;

  initial begin
    bit ok;
    int p;
    logic [15:0] ib;
    for (int i = 0; i < 256; i++) begin imem[i] = 8'hFF; dmem[i] = 32'h0; end
    dmem[AB[7:0]] = 32'h8000_0005;
    dmem[AC[7:0]] = 32'h7FFF_FFFF;
    dmem[8'h01]   = 32'hDEAD_0001;
    dmem[8'h02]   = 32'hDEAD_0002;
    dmem[8'h03]   = 32'hDEAD_0003;
    p = 0;
    putIns(p, 8'h01, AB); putIns(p, 8'h10, AC); putIns(p, 8'h02, AA);
    putIns(p, 8'h10, AC); putIns(p, 8'h02, AB);
    putIns(p, 8'h01, AA); putIns(p, 8'h11, AB); putIns(p, 8'h02, AD);
    imem[p[7:0]] = 8'hFF;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(acc == 0 && instBytes == 0 && dataBytes == 0 && !done && !error,
          "R1 reset state", {acc, instBytes}, 48'd0);
    buildExpected();
    runAndWait(ok);
    if (ok) begin
      check(cyc == expCycles, "R11 cycles per program", 48'(cyc), 48'(expCycles));
      check(acc == expAcc, "R6 final accumulator (sub)", 48'(acc), 48'(expAcc));
      check(dmem[AA[7:0]] == 32'h0000_0004, "R5 add wraps A", 48'(dmem[AA[7:0]]), 48'h4);
      check(dmem[AB[7:0]] == 32'h8000_0003, "R3 R5 load/add B", 48'(dmem[AB[7:0]]), 48'h80000003);
      check(dmem[AD[7:0]] == 32'h8000_0001, "R6 sub minuend D", 48'(dmem[AD[7:0]]), 48'h80000001);
      check(instBytes == 16'(expInst), "R9 instruction bytes", 48'(instBytes), 48'(expInst));
      check(dataBytes == 16'(expData), "R10 data bytes", 48'(dataBytes), 48'(expData));
      check(!error, "R7 halt without error", 48'(error), 48'd0);
      check(expQ.size() == 0, "R4 all writes seen", 48'(expQ.size()), 48'd0);
      ib = instBytes;
      repeat (10) @(negedge clk);
      check(instBytes == ib && !instRd && done && acc == expAcc, "R7 frozen after halt",
            48'(instBytes), 48'(ib));
    end

    // Second program: unknown opcode after a load
    rstN = 1'b0;
    expQ.delete();
    for (int i = 0; i < 256; i++) imem[i] = 8'hFF;
    p = 0;
    putIns(p, 8'h01, AB);
    imem[p[7:0]] = 8'h33; p++;
    putIns(p, 8'h02, AD);
    dmem[AD[7:0]] = 32'h1234_5678;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(acc == 0 && instBytes == 0 && dataBytes == 0 && !done && !error,
          "R1 reset clears after run", {acc, instBytes}, 48'd0);
    buildExpected();
    runAndWait(ok);
    if (ok) begin
      check(error && expErr, "R8 error on unknown opcode", 48'(error), 48'd1);
      check(instBytes == 16'd4 && dataBytes == 16'd4, "R8 R9 R10 traffic stops",
            {16'd0, instBytes, dataBytes}, {16'd0, 16'd4, 16'd4});
      check(acc == 32'h8000_0003, "R3 load before error", 48'(acc), 48'h80000003);
      repeat (10) @(negedge clk);
      check(dmem[AD[7:0]] == 32'h1234_5678 && instBytes == 16'd4 && done,
            "R8 no access after error", 48'(dmem[AD[7:0]]), 48'h12345678);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule